// File: doc/BRIEF.md
# Supply Protection Sequencing Controller

This block is the digital supervisor that sits behind a set of supply comparators and decides when a series pass switch may conduct. It takes single-bit comparator results as inputs: undervoltage, the upper and lower overvoltage trip points, overcurrent across the sense element, and "gate is fully up". It also takes an active-low enable. From these it drives one of three gate actions: slow ramp-up, strong discharge or gentle discharge. It also drives a sleep flag and an active-low power-good.

Every comparator input passes through a two-stage synchronizer. All timing comes from cycle counters. Their lengths are given in microseconds and converted with the clock-frequency parameter. The timers are the start-up qualification delay, the overcurrent persistence filter, the power-good qualification delay and the latch-release hold time. A single parameter selects what happens after an overcurrent trip. In one setting the controller latches off. In the other it retries after a fresh start-up delay.

Top module: `supply_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls with `uv_in` high, `gate_fast_off`=1, `gate_ramp`=0, `gate_soft_off`=0, `sleep`=0 and `pgood_n`=1.
- R2: After `uv_in` falls with `en_n_in` low, `gate_ramp` rises exactly START cycles after the controller enters its delay state. That is 3+START clock edges after the input change: 2 synchronizer stages and 1 output register.
- R3: An overvoltage or undervoltage seen during the start-up delay clears the delay count to zero, so the full START cycles are counted again from the end of the disturbance.
- R4: Overvoltage is set when `ov_rise_in` is 1. It then stays set for as long as `ov_fall_in` is 1, even after `ov_rise_in` returns to 0.
- R5: Overvoltage while the gate ramps is not filtered: `gate_ramp` falls and `gate_fast_off` rises 3 edges after `ov_rise_in` rises, and `pgood_n` goes to 1 on the same edge.
- R6: Overcurrent trips only when `oc_in` has been 1 in OC consecutive synchronized samples. A shorter pulse resets the filter and has no effect on the outputs. A trip drives `gate_fast_off`=1 and `pgood_n`=1.
- R7: With AUTO_RETRY=1, a trip is followed by START cycles of delay and then `gate_ramp`=1 again.
- R8: With AUTO_RETRY=0, the switch stays off after a trip until `uv_in` or `en_n_in` has been 1 for CLR consecutive synchronized samples. A shorter hold leaves it off. After release the full start-up sequence runs.
- R9: `en_n_in`=1 replaces any gate action with `gate_soft_off`=1 and `sleep`=1, with `pgood_n`=1. Returning it to 0 starts a full START-cycle delay.
- R10: `pgood_n` falls PG cycles after `gate_hi_in` is seen high while ramping. It rises 3 edges after `gate_hi_in` falls. It is never 0 unless `gate_ramp` is 1.
- R11: Undervoltage has top priority: with `uv_in`=1 the gate is discharged strongly and `pgood_n`=1 in every state.
- R12: Exactly one of `gate_ramp`, `gate_fast_off`, `gate_soft_off` is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_in | input | 1 | Supply below lockout level |
| ov_rise_in | input | 1 | Supply above upper overvoltage trip point |
| ov_fall_in | input | 1 | Supply above lower (recovery) trip point |
| oc_in | input | 1 | Sense voltage above overcurrent limit |
| gate_hi_in | input | 1 | Gate voltage above its "fully on" level |
| en_n_in | input | 1 | Active-low enable; high requests sleep |
| gate_ramp | output | 1 | Enable slow gate charge |
| gate_fast_off | output | 1 | Strong gate discharge |
| gate_soft_off | output | 1 | Weak gate discharge |
| sleep | output | 1 | Low-power sleep indication |
| pgood_n | output | 1 | Active-low power good |

## Verification
The assertions assume that comparator inputs are level signals: once changed, they hold for at least the two synchronizer cycles they take to reach the state machine. They also assume the overvoltage pair is consistent, so `ov_rise_in` high implies `ov_fall_in` high. The stimulus changes inputs only just after a clock edge and always raises and drops both overvoltage inputs together or drops the upper one first. Every pulse is at least one full cycle wide, so no comparator event is shorter than a synchronizer sample.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    ST_UVHOLD = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_DELAY  = 3'd2,
    ST_ON     = 3'd3,
    ST_LATCH  = 3'd4
  } guard_state_e;

  // cycles for a given duration; clock is an integer number of MHz
  function automatic int unsigned us_to_cycles(int unsigned clk_hz, int unsigned us);
    int unsigned c;
    c = (clk_hz / 1_000_000) * us;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int          N       = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
      end else begin
        meta   <= d[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/sg_timer.sv
module sg_timer
  import supply_guard_pkg::*;
#(
  parameter int unsigned LIM = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned W = cnt_width(LIM);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic [W-1:0] cnt;

  // done holds while run stays high so the count saturates
  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned START_US   = 130_000,
  parameter int unsigned OC_US      = 10,
  parameter int unsigned PG_US      = 65_000,
  parameter int unsigned CLR_US     = 500,
  parameter bit          AUTO_RETRY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_in,
  input  logic ov_rise_in,
  input  logic ov_fall_in,
  input  logic oc_in,
  input  logic gate_hi_in,
  input  logic en_n_in,
  output logic gate_ramp,
  output logic gate_fast_off,
  output logic gate_soft_off,
  output logic sleep,
  output logic pgood_n
);
  localparam int unsigned START_CYC = us_to_cycles(CLK_HZ, START_US);
  localparam int unsigned OC_CYC    = us_to_cycles(CLK_HZ, OC_US);
  localparam int unsigned PG_CYC    = us_to_cycles(CLK_HZ, PG_US);
  localparam int unsigned CLR_CYC   = us_to_cycles(CLK_HZ, CLR_US);
  localparam int          NSYNC     = 6;

  // synchronized comparator bundle
  logic [NSYNC-1:0] raw_in, syn;
  logic uv_s, ovr_s, ovf_s, oc_s, ghi_s, en_s;

  assign raw_in = {en_n_in, gate_hi_in, oc_in, ov_fall_in, ov_rise_in, uv_in};

  sg_sync #(.N(NSYNC), .RST_VAL(6'b000001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn)
  );

  assign {en_s, ghi_s, oc_s, ovf_s, ovr_s, uv_s} = syn;

  // overvoltage with hysteresis between upper and lower trip points
  logic ov_hold, ov_now;
  assign ov_now = ovr_s || (ov_hold && ovf_s);

  always_ff @(posedge clk) begin
    if (rst) ov_hold <= 1'b0;
    else     ov_hold <= ov_now;
  end

  guard_state_e state, nxt;

  // timers
  logic run_start, run_oc, run_pg, run_clr;
  logic start_done, oc_done, pg_done, clr_done;

  assign run_start = (state == ST_DELAY) && !ov_now;
  assign run_oc    = (state == ST_ON) && oc_s;
  assign run_pg    = (state == ST_ON) && ghi_s;
  assign run_clr   = (state == ST_LATCH) && (uv_s || en_s);

  sg_timer #(.LIM(START_CYC)) u_t_start (
    .clk(clk), .rst(rst), .run(run_start), .done(start_done));
  sg_timer #(.LIM(OC_CYC)) u_t_oc (
    .clk(clk), .rst(rst), .run(run_oc), .done(oc_done));
  sg_timer #(.LIM(PG_CYC)) u_t_pg (
    .clk(clk), .rst(rst), .run(run_pg), .done(pg_done));
  sg_timer #(.LIM(CLR_CYC)) u_t_clr (
    .clk(clk), .rst(rst), .run(run_clr), .done(clr_done));

  // destination after an overcurrent trip
  guard_state_e oc_dest;
  if (AUTO_RETRY) begin : g_retry
    assign oc_dest = ST_DELAY;
  end else begin : g_latch
    assign oc_dest = ST_LATCH;
  end

  // next-state logic, priority: uv > ov > oc > enable
  always_comb begin
    nxt = state;
    unique case (state)
      ST_UVHOLD: begin
        if (!uv_s) nxt = en_s ? ST_SLEEP : ST_DELAY;
      end
      ST_SLEEP: begin
        if (uv_s)       nxt = ST_UVHOLD;
        else if (!en_s) nxt = ST_DELAY;
      end
      ST_DELAY: begin
        if (uv_s)            nxt = ST_UVHOLD;
        else if (en_s)       nxt = ST_SLEEP;
        else if (start_done) nxt = ST_ON;
      end
      ST_ON: begin
        if (uv_s)         nxt = ST_UVHOLD;
        else if (ov_now)  nxt = ST_DELAY;
        else if (oc_done) nxt = oc_dest;
        else if (en_s)    nxt = ST_SLEEP;
      end
      ST_LATCH: begin
        if (clr_done) nxt = ST_UVHOLD;
      end
      default: nxt = ST_UVHOLD;
    endcase
  end

  // state and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_UVHOLD;
      gate_ramp     <= 1'b0;
      gate_fast_off <= 1'b1;
      gate_soft_off <= 1'b0;
      sleep         <= 1'b0;
      pgood_n       <= 1'b1;
    end else begin
      state         <= nxt;
      gate_ramp     <= (nxt == ST_ON);
      gate_fast_off <= (nxt == ST_UVHOLD) || (nxt == ST_DELAY) || (nxt == ST_LATCH);
      gate_soft_off <= (nxt == ST_SLEEP);
      sleep         <= (nxt == ST_SLEEP);
      pgood_n       <= !((nxt == ST_ON) && pg_done);
    end
  end
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
  input logic clk,
  input logic rst,
  input logic uv_in,
  input logic ov_rise_in,
  input logic gate_hi_in,
  input logic gate_ramp,
  input logic gate_fast_off,
  input logic gate_soft_off,
  input logic sleep,
  input logic pgood_n
);
  p_gate_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({gate_ramp, gate_fast_off, gate_soft_off}) == 1);

  p_uv_hold_r11: assert property (@(posedge clk) disable iff (rst)
    uv_in && $past(uv_in) && $past(uv_in, 2) |=> gate_fast_off && pgood_n);

  p_ov_off_r5: assert property (@(posedge clk) disable iff (rst)
    gate_ramp && ov_rise_in && $past(ov_rise_in) && $past(ov_rise_in, 2) |=> !gate_ramp);

  p_pg_needs_ramp_r10: assert property (@(posedge clk) disable iff (rst)
    !pgood_n |-> gate_ramp);

  p_pg_gatehi_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(pgood_n) |-> $past(gate_hi_in, 2));

  p_ramp_after_delay_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_ramp) |-> $past(gate_fast_off));

  p_sleep_soft_r9: assert property (@(posedge clk) disable iff (rst)
    sleep |-> gate_soft_off && pgood_n);
endmodule

bind supply_guard supply_guard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .uv_in         (uv_in),
  .ov_rise_in    (ov_rise_in),
  .gate_hi_in    (gate_hi_in),
  .gate_ramp     (gate_ramp),
  .gate_fast_off (gate_fast_off),
  .gate_soft_off (gate_soft_off),
  .sleep         (sleep),
  .pgood_n       (pgood_n)
);

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int START = 20, OCN = 4, PGN = 10, CLRN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv_in = 1'b1, ov_rise_in = 1'b0, ov_fall_in = 1'b0;
  logic oc_in = 1'b0, gate_hi_in = 1'b0, en_n_in = 1'b0;

  logic l_ramp, l_fast, l_soft, l_sleep, l_pg_n;
  logic a_ramp, a_fast, a_soft, a_sleep, a_pg_n;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  supply_guard #(.CLK_HZ(CLK_HZ), .START_US(START), .OC_US(OCN), .PG_US(PGN),
                 .CLR_US(CLRN), .AUTO_RETRY(1'b0)) u_supply_guard (
    .clk(clk), .rst(rst), .uv_in(uv_in), .ov_rise_in(ov_rise_in),
    .ov_fall_in(ov_fall_in), .oc_in(oc_in), .gate_hi_in(gate_hi_in),
    .en_n_in(en_n_in), .gate_ramp(l_ramp), .gate_fast_off(l_fast),
    .gate_soft_off(l_soft), .sleep(l_sleep), .pgood_n(l_pg_n));

  supply_guard #(.CLK_HZ(CLK_HZ), .START_US(START), .OC_US(OCN), .PG_US(PGN),
                 .CLR_US(CLRN), .AUTO_RETRY(1'b1)) u_supply_guard_ar (
    .clk(clk), .rst(rst), .uv_in(uv_in), .ov_rise_in(ov_rise_in),
    .ov_fall_in(ov_fall_in), .oc_in(oc_in), .gate_hi_in(gate_hi_in),
    .en_n_in(en_n_in), .gate_ramp(a_ramp), .gate_fast_off(a_fast),
    .gate_soft_off(a_soft), .sleep(a_sleep), .pgood_n(a_pg_n));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1", "fast", l_fast, 1'b1);  chk("R1", "ramp", l_ramp, 1'b0);
    chk("R1", "soft", l_soft, 1'b0);  chk("R1", "sleep", l_sleep, 1'b0);
    chk("R1", "pg_n", l_pg_n, 1'b1);  chk("R1", "ar fast", a_fast, 1'b1);

    // R2 start-up delay from undervoltage release
    uv_in = 1'b0;
    tick(3 + START - 1);
    chk("R2", "ramp early", l_ramp, 1'b0);
    tick(1);
    chk("R2", "ramp on", l_ramp, 1'b1);  chk("R2", "fast off", l_fast, 1'b0);
    chk("R2", "ar ramp on", a_ramp, 1'b1);

    // R10 power-good qualification and release
    gate_hi_in = 1'b1;
    tick(2 + PGN - 1);
    chk("R10", "pg early", l_pg_n, 1'b1);
    tick(1);
    chk("R10", "pg asserted", l_pg_n, 1'b0);
    gate_hi_in = 1'b0;
    tick(2);
    chk("R10", "pg held", l_pg_n, 1'b0);
    tick(1);
    chk("R10", "pg released", l_pg_n, 1'b1);
    gate_hi_in = 1'b1;
    tick(2 + PGN);
    chk("R10", "pg again", l_pg_n, 1'b0);

    // R6 short overcurrent glitch ignored
    oc_in = 1'b1;
    tick(OCN - 1);
    oc_in = 1'b0;
    tick(6);
    chk("R6", "glitch ramp", l_ramp, 1'b1);  chk("R6", "glitch pg", l_pg_n, 1'b0);

    // R9 sleep entry and exit
    en_n_in = 1'b1;
    tick(2);
    chk("R9", "ramp before", l_ramp, 1'b1);
    tick(1);
    chk("R9", "soft", l_soft, 1'b1);  chk("R9", "sleep", l_sleep, 1'b1);
    chk("R9", "ramp", l_ramp, 1'b0);  chk("R9", "pg_n", l_pg_n, 1'b1);
    en_n_in = 1'b0;
    tick(3);
    chk("R9", "wake fast", l_fast, 1'b1);  chk("R9", "wake sleep", l_sleep, 1'b0);
    tick(START - 1);
    chk("R9", "delay ramp", l_ramp, 1'b0);
    tick(1);
    chk("R9", "restart ramp", l_ramp, 1'b1);
    tick(PGN - 1);
    chk("R10", "requal early", l_pg_n, 1'b1);
    tick(1);
    chk("R10", "requal", l_pg_n, 1'b0);

    // R5 immediate overvoltage shutdown, R4 hysteresis
    ov_rise_in = 1'b1; ov_fall_in = 1'b1;
    tick(2);
    chk("R5", "ramp before", l_ramp, 1'b1);
    tick(1);
    chk("R5", "fast", l_fast, 1'b1);  chk("R5", "ramp", l_ramp, 1'b0);
    chk("R5", "pg_n", l_pg_n, 1'b1);
    ov_rise_in = 1'b0;
    tick(40);
    chk("R4", "held by lower point", l_ramp, 1'b0);
    chk("R4", "held fast", l_fast, 1'b1);
    ov_fall_in = 1'b0;
    tick(10);
    // R3 one-cycle overvoltage pulse restarts delay
    ov_rise_in = 1'b1; ov_fall_in = 1'b1;
    tick(1);
    ov_rise_in = 1'b0; ov_fall_in = 1'b0;
    tick(21);
    chk("R3", "restarted ramp", l_ramp, 1'b0);
    tick(1);
    chk("R3", "ramp after full delay", l_ramp, 1'b1);

    // R6 sustained overcurrent trips; R7 retry; R8 latch
    oc_in = 1'b1;
    tick(2 + OCN - 1);
    chk("R6", "before trip", l_ramp, 1'b1);
    tick(1);
    chk("R6", "trip ramp", l_ramp, 1'b0);  chk("R6", "trip fast", l_fast, 1'b1);
    chk("R6", "trip pg", l_pg_n, 1'b1);    chk("R6", "ar trip", a_ramp, 1'b0);
    oc_in = 1'b0;
    tick(START - 1);
    chk("R7", "retry early", a_ramp, 1'b0);
    tick(1);
    chk("R7", "retry ramp", a_ramp, 1'b1);
    chk("R8", "latched ramp", l_ramp, 1'b0);
    tick(50);
    chk("R8", "still latched", l_fast, 1'b1);  chk("R8", "still off", l_ramp, 1'b0);

    en_n_in = 1'b1;
    tick(CLRN - 1);
    en_n_in = 1'b0;
    tick(40);
    chk("R8", "short hold fast", l_fast, 1'b1);  chk("R8", "short hold sleep", l_sleep, 1'b0);
    en_n_in = 1'b1;
    tick(2 + CLRN);
    chk("R8", "not yet sleep", l_sleep, 1'b0);
    tick(1);
    chk("R8", "released to sleep", l_sleep, 1'b1);
    en_n_in = 1'b0;
    tick(3 + START - 1);
    chk("R8", "restart early", l_ramp, 1'b0);
    tick(1);
    chk("R8", "restart ramp", l_ramp, 1'b1);

    // R11 undervoltage while on
    tick(5);
    uv_in = 1'b1;
    tick(2);
    chk("R11", "ramp before", l_ramp, 1'b1);
    tick(1);
    chk("R11", "fast", l_fast, 1'b1);  chk("R11", "pg", l_pg_n, 1'b1);
    chk("R11", "ar fast", a_fast, 1'b1);
    chk("R12", "single action", l_ramp | l_soft, 1'b0);
    uv_in = 1'b0;
    tick(3 + START);
    chk("R2", "ramp after uv", l_ramp, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule